// File: doc/BRIEF.md
# Oneshot/Periodic Countdown Event Timer Channel

This block is a single countdown channel meant to serve one processor as its event timer. It advances only when the shared microsecond tick enable is high. Software programs it through one control word, which carries the start flag, the repeat flag and a 29-bit count. A second word shows the remaining count and the pending-interrupt flag, and a write to that word acknowledges the interrupt.

The count follows an n+1 rule. Loading N makes the channel expire on the (N+1)th tick, so a load of zero fires on the very next tick. At expiry the channel raises a level interrupt. In oneshot mode it then stops. In periodic mode it reloads the programmed count and keeps running with a period of N+1 ticks. A control write of all zeros stops the channel.

The host side is a simple synchronous write port with a combinational read port. The channel occupies one 8-byte slot, with the control word at offset 0x0 and the status word at offset 0x4.

Top module: `evt_timer_chan`

## Requirements
- R1: After synchronous reset the interrupt output is 0 and both the control word and the status word read as 0.
- R2: A write to offset 0x0 stores the start flag from bit 31, the repeat flag from bit 30 and the count from bits 28:0. Reading offset 0x0 returns those three fields in the same bit positions, with every other bit 0.
- R3: While the channel runs, the remaining count drops by one on each cycle with tick_en high and holds on cycles with tick_en low. After a load of N, irq rises on the (N+1)th tick and not before. A load of 0 fires after a single tick.
- R4: In oneshot mode (bit 30 = 0) the start flag clears by itself at expiry. The remaining count then stays 0 and no further expiry occurs until the control word is written again.
- R5: In periodic mode (bit 30 = 1) the count reloads to the programmed value at each expiry, and the channel expires again every N+1 ticks.
- R6: Writing 0 to the control word stops the channel. The count then holds at 0 and ticks cause no expiry.
- R7: Reading offset 0x4 returns the remaining count in bits 28:0 and the interrupt flag in bit 30, with every other bit 0.
- R8: A write to offset 0x4 with bit 30 = 1 clears the interrupt flag. A write to offset 0x4 with bit 30 = 0 leaves the flag unchanged.
- R9: When an expiry and a clear write fall on the same cycle, the flag is set after that cycle.
- R10: A control write with the start flag set restarts the countdown from the new value at once, discarding the count in progress.
- R11: Writes to offsets other than 0x0 and 0x4 change nothing, and reads from those offsets return 0.
- R12: The interrupt flag is a level. Once set, it stays set through idle cycles and further ticks until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Microsecond tick enable, one cycle wide per tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | OFF_W (3) | Byte offset within the channel slot |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt, high while the flag is pending |

## Verification
A write or a tick takes effect at the clock edge where it is presented. A new count or a cleared flag is therefore visible on `rdata` and `irq` in the following low phase, and an expiry raised by the (N+1)th tick shows on `irq` right after that same edge, with no extra pipeline stage. The bench drives every input at the falling edge, holds it for exactly one rising edge, and samples the outputs at the next falling edge. Each tick count in a check is therefore the exact number of rising edges with tick_en high. Reads are combinational and are sampled one time unit after the address settles.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int DATA_W   = 32;
    localparam int CNT_W    = 29;
    localparam int RUN_POS  = 31;
    localparam int REP_POS  = 30;
    localparam int ACK_POS  = 30;
    localparam int FLAG_POS = 30;

    localparam logic [7:0] CTRL_OFF = 8'h00;
    localparam logic [7:0] STAT_OFF = 8'h04;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic run;
        logic repeat_mode;
        cnt_t count;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2
    } reg_sel_e;

    function automatic chan_cfg_t cfg_from_word(word_t w);
        chan_cfg_t c;
        c.run         = w[RUN_POS];
        c.repeat_mode = w[REP_POS];
        c.count       = w[CNT_W-1:0];
        return c;
    endfunction

    function automatic word_t cfg_to_word(chan_cfg_t c);
        word_t w;
        w               = '0;
        w[RUN_POS]      = c.run;
        w[REP_POS]      = c.repeat_mode;
        w[CNT_W-1:0]    = c.count;
        return w;
    endfunction

    function automatic word_t stat_to_word(cnt_t remaining, logic flag);
        word_t w;
        w               = '0;
        w[FLAG_POS]     = flag;
        w[CNT_W-1:0]    = remaining;
        return w;
    endfunction

endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_timer_pkg::*;
#(
    parameter int OFF_W = 3
) (
    input  logic             wr_en,
    input  logic [OFF_W-1:0] addr,
    input  word_t            wdata,
    input  chan_cfg_t        cfg,
    input  cnt_t             remaining,
    input  logic             flag,
    output logic             load_req,
    output chan_cfg_t        load_cfg,
    output logic             ack_req,
    output word_t            rdata
);

    localparam logic [OFF_W-1:0] CTRL_A = CTRL_OFF[OFF_W-1:0];
    localparam logic [OFF_W-1:0] STAT_A = STAT_OFF[OFF_W-1:0];

    reg_sel_e sel;

    always_comb begin
        if (addr == CTRL_A)      sel = SEL_CTRL;
        else if (addr == STAT_A) sel = SEL_STAT;
        else                     sel = SEL_NONE;
    end

    always_comb begin
        load_req = wr_en && (sel == SEL_CTRL);
        load_cfg = cfg_from_word(wdata);
        ack_req  = wr_en && (sel == SEL_STAT) && wdata[ACK_POS];
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL: rdata = cfg_to_word(cfg);
            SEL_STAT: rdata = stat_to_word(remaining, flag);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
    import evt_timer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_en,
    input  logic      load_req,
    input  chan_cfg_t load_cfg,
    output chan_cfg_t cfg,
    output cnt_t      remaining,
    output logic      expire
);

    chan_cfg_t cfg_q;
    cnt_t      cnt_q;
    logic      at_zero;

    assign at_zero = (cnt_q == '0);

    // A control write in the same cycle takes precedence over the tick.
    always_comb begin
        expire = tick_en && cfg_q.run && at_zero && !load_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            cnt_q <= '0;
        end else if (load_req) begin
            cfg_q <= load_cfg;
            cnt_q <= load_cfg.count;
        end else if (expire) begin
            if (cfg_q.repeat_mode) begin
                cnt_q <= cfg_q.count;
            end else begin
                cfg_q.run <= 1'b0;
            end
        end else if (tick_en && cfg_q.run) begin
            cnt_q <= cnt_q - cnt_t'(1);
        end
    end

    assign cfg       = cfg_q;
    assign remaining = cnt_q;

endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic ack_req,
    output logic flag
);

    logic flag_q;

    // Expiry wins over an acknowledge in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)          flag_q <= 1'b0;
        else if (set_req) flag_q <= 1'b1;
        else if (ack_req) flag_q <= 1'b0;
    end

    assign flag = flag_q;

endmodule

// File: rtl/evt_timer_chan.sv
module evt_timer_chan
    import evt_timer_pkg::*;
#(
    parameter int OFF_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             irq
);

    chan_cfg_t cur_cfg;
    chan_cfg_t new_cfg;
    cnt_t      cur_cnt;
    logic      do_load;
    logic      do_ack;
    logic      fired;

    evt_timer_regs #(.OFF_W(OFF_W)) u_regs (
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .cfg       (cur_cfg),
        .remaining (cur_cnt),
        .flag      (irq),
        .load_req  (do_load),
        .load_cfg  (new_cfg),
        .ack_req   (do_ack),
        .rdata     (rdata)
    );

    evt_timer_core u_core (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .load_req  (do_load),
        .load_cfg  (new_cfg),
        .cfg       (cur_cfg),
        .remaining (cur_cnt),
        .expire    (fired)
    );

    evt_timer_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .set_req (fired),
        .ack_req (do_ack),
        .flag    (irq)
    );

endmodule

// File: rtl/evt_timer_chan_chk.sv
module evt_timer_chan_chk
    import evt_timer_pkg::*;
#(
    parameter int OFF_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             wr_en,
    input logic [OFF_W-1:0] addr,
    input logic [31:0]      wdata,
    input logic             irq,
    input chan_cfg_t        cfg,
    input cnt_t             cnt,
    input logic             fired
);

    logic wr_ctrl;
    logic wr_clear;
    assign wr_ctrl  = wr_en && (addr == CTRL_OFF[OFF_W-1:0]);
    assign wr_clear = wr_en && (addr == STAT_OFF[OFF_W-1:0]) && wdata[ACK_POS];

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!irq && cnt == '0 && !cfg.run));

    // R3
    tick_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.run && tick_en && !wr_ctrl && cnt != '0) |=> (cnt == $past(cnt) - cnt_t'(1)));

    // R4
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (fired && !cfg.repeat_mode) |=> (!cfg.run && cnt == '0));

    // R5
    periodic_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (fired && cfg.repeat_mode) |=> (cfg.run && cnt == $past(cfg.count)));

    // R6
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg.run && !wr_ctrl) |=> $stable(cnt));

    // R9
    expire_sets_chk: assert property (@(posedge clk) disable iff (rst)
        fired |=> irq);

    // R12
    flag_level_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_clear) |=> irq);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_clear && !fired) |=> !irq);

endmodule

bind evt_timer_chan evt_timer_chan_chk #(.OFF_W(OFF_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .irq     (irq),
    .cfg     (cur_cfg),
    .cnt     (cur_cnt),
    .fired   (fired)
);

// File: tb/sim_evt_timer_chan.sv
`timescale 1ns/1ps
module sim_evt_timer_chan;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    evt_timer_chan #(.OFF_W(3)) u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 32'd0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic ticks(int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(3'd0, v); chk("R1 ctrl", v, 32'd0);
        rd(3'd4, v); chk("R1 stat", v, 32'd0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        wr(3'd0, 32'h8000_0003);
        rd(3'd0, v); chk("R2 ctrl readback", v, 32'h8000_0003);
        ticks(3);
        chk("R3 no early irq", {31'd0, irq}, 32'd0);
        rd(3'd4, v); chk("R3 count at zero", v, 32'd0);
        ticks(1);
        chk("R3 irq on tick N+1", {31'd0, irq}, 32'd1);
        rd(3'd0, v); chk("R4 run cleared", v, 32'h0000_0003);
        rd(3'd4, v); chk("R7 status flag", v, 32'h4000_0000);
        ticks(5);
        rd(3'd4, v); chk("R4 count held", v, 32'h4000_0000);
        idle(4);
        chk("R12 flag held", {31'd0, irq}, 32'd1);
        wr(3'd4, 32'h0000_0000);
        chk("R8 no clear without bit30", {31'd0, irq}, 32'd1);
        wr(3'd4, 32'h4000_0000);
        chk("R8 cleared", {31'd0, irq}, 32'd0);
        ticks(3);
        chk("R4 no refire", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_zero_load();
        wr(3'd0, 32'h8000_0000);
        ticks(1);
        chk("R3 zero load fires after one tick", {31'd0, irq}, 32'd1);
        wr(3'd4, 32'h4000_0000);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        wr(3'd0, 32'hC000_0002);
        ticks(3);
        chk("R5 first expiry", {31'd0, irq}, 32'd1);
        rd(3'd4, v); chk("R5 R7 reloaded status", v, 32'h4000_0002);
        wr(3'd4, 32'h4000_0000);
        ticks(2);
        chk("R5 not yet second expiry", {31'd0, irq}, 32'd0);
        ticks(1);
        chk("R5 second expiry", {31'd0, irq}, 32'd1);
        wr(3'd0, 32'h0000_0000);
        wr(3'd4, 32'h4000_0000);
        ticks(10);
        chk("R6 stopped no irq", {31'd0, irq}, 32'd0);
        rd(3'd4, v); chk("R6 stopped count", v, 32'd0);
        rd(3'd0, v); chk("R6 ctrl zero", v, 32'd0);
    endtask

    task automatic t_gating();
        logic [31:0] v;
        wr(3'd0, 32'h8000_0001);
        idle(5);
        rd(3'd4, v); chk("R3 no tick no step", v, 32'h0000_0001);
        ticks(1);
        rd(3'd4, v); chk("R3 one step", v, 32'd0);
        wr(3'd0, 32'h0000_0000);
    endtask

    task automatic t_restart();
        logic [31:0] v;
        wr(3'd0, 32'h8000_0005);
        ticks(3);
        rd(3'd4, v); chk("R10 mid count", v, 32'h0000_0002);
        wr(3'd0, 32'h8000_0001);
        rd(3'd4, v); chk("R10 restarted", v, 32'h0000_0001);
        ticks(1);
        chk("R10 not yet", {31'd0, irq}, 32'd0);
        ticks(1);
        chk("R10 fires N+1 after restart", {31'd0, irq}, 32'd1);
        wr(3'd4, 32'h4000_0000);
    endtask

    task automatic t_race();
        wr(3'd0, 32'h8000_0000);
        ticks(1);
        wr(3'd0, 32'h8000_0000);
        tick_en = 1'b1;
        wr(3'd4, 32'h4000_0000);
        tick_en = 1'b0;
        chk("R9 expiry beats clear", {31'd0, irq}, 32'd1);
        wr(3'd4, 32'h4000_0000);
        chk("R9 later clear", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd6, 32'hC000_0007);
        rd(3'd0, v); chk("R11 ctrl untouched", v, 32'd0);
        rd(3'd1, v); chk("R11 unmapped read", v, 32'd0);
        ticks(2);
        chk("R11 no irq", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_oneshot();
        t_zero_load();
        t_periodic();
        t_gating();
        t_restart();
        t_race();
        t_unmapped();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule